// File: doc/BRIEF.md
# Masked Pattern Match Interrupt

This block watches a 32-bit digital input word and raises an interrupt request in one of two ways: when the unmasked bits of the input all equal a programmed compare word (match mode), or when any unmasked bit changes between two consecutive samples (event mode). Software programs a mode, a per-bit ignore mask and a compare word through three write strobes that share one data bus.

The raw input is first passed through a two-stage synchronizer. Every interrupt copies the synchronized word into a capture register and sets a sticky status flag. The flag drives the interrupt request and stays set until software writes a 1 to its bit position. The capture register keeps its value until the next interrupt, so software can read the exact word that caused it.

Top module: `pattern_match_irq`

## Requirements
- R1: After a synchronous active-low reset, the interrupt request is 0, the status word is all zeros, the capture value is 0 and the mode is disabled (encoding 0). The mask and the compare word are 0.
- R2: With mode encoding 0 or 3 (disabled), no input change and no compare condition raises the interrupt.
- R3: A mask bit of 1 excludes that input bit from both match and event detection. A mask bit of 0 includes it.
- R4: In match mode (encoding 1), the interrupt fires on the cycle in which every unmasked synchronized input bit becomes equal to its compare bit. It fires only on the transition into the matching condition and not again while the match holds.
- R5: In event mode (encoding 2), the interrupt fires on every cycle in which at least one unmasked bit of the synchronized input differs from its value one sample earlier.
- R6: When the interrupt fires, the capture output takes the synchronized input word that caused it. Otherwise the capture output holds its value.
- R7: The status output has the interrupt flag at bit 1, and all other status bits read 0. The flag is sticky, and the interrupt request output equals it. A clear write with data bit 1 set clears the flag. A clear write with data bit 1 at 0 has no effect. If a new interrupt fires in the same cycle as a clear, the set wins.
- R8: An input change that is held stable is seen by the detector after two clock edges. The resulting interrupt and capture appear after the third rising edge that follows the change.
- R9: A register write takes effect at the clock edge that samples its strobe. Data bits [1:0] select the mode, and the full 32-bit data word sets the mask or the compare word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 32 | Raw digital input word |
| wdata | input | 32 | Write data shared by all strobes |
| mode_we | input | 1 | Write wdata[1:0] to the mode register |
| mask_we | input | 1 | Write wdata to the ignore mask |
| comp_we | input | 1 | Write wdata to the compare word |
| clr_we | input | 1 | Clear the status bits set in wdata |
| irq_o | output | 1 | Interrupt request (sticky flag) |
| stat_o | output | 8 | Status word, flag at bit 1 |
| capt_o | output | 32 | Input word latched at the last interrupt |

## Verification
Match mode is first driven with a word whose upper half is masked and whose lower half equals the compare word. Then only masked bits are changed, and then an unmasked bit leaves the match and returns to it. These steps separate a correct mask polarity and a correct edge-only firing from a level-triggered or inverted-mask design. In event mode, a change on a masked bit is followed by a change on an unmasked bit, and the interrupt is sampled one cycle before and on its expected cycle, which pins the synchronizer depth. A long stretch of random input words, mode changes and clear writes (including clears that coincide with new interrupts) is then compared cycle by cycle against a behavioural model that keeps a history queue of the input samples.

// File: rtl/pmi_pkg.sv
// Package: shared mode encodings and the status bit position for the
// masked pattern match interrupt block. Assumes a 2-bit mode field.
package pmi_pkg;
    typedef enum logic [1:0] {
        PMI_OFF   = 2'd0,
        PMI_MATCH = 2'd1,
        PMI_EVENT = 2'd2
    } pmi_mode_e;

    localparam int unsigned PMI_IRQ_BIT = 1;
endpackage

// File: rtl/pmi_sync.sv
// Module: multi-stage flop synchronizer for a data word.
// Assumes the downstream logic tolerates bit skew between lanes.
module pmi_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage resamples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pmi_detect.sv
// Module: detects a masked match transition or a masked change on the
// synchronized word. Mask bit 1 means ignore. Assumes the mode, mask and
// compare values come from registers.
module pmi_detect
    import pmi_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] comp_i,
    output logic         fire_o
);
    logic [W-1:0] prev_q;
    logic         match_q;
    logic         match_now;
    logic         changed;

    // Combinational match and change terms over the unmasked lanes.
    always_comb begin
        match_now = &((word_i ~^ comp_i) | mask_i);
        changed   = |((word_i ^ prev_q) & ~mask_i);
    end

    // Remember the previous sample and the previous match state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            match_q <= 1'b0;
        end else begin
            prev_q  <= word_i;
            match_q <= match_now;
        end
    end

    // Select the firing condition from the mode.
    always_comb begin
        case (mode_i)
            PMI_MATCH: fire_o = match_now & ~match_q;
            PMI_EVENT: fire_o = changed;
            default:   fire_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmi_capture.sv
// Module: capture register and sticky interrupt flag. A set wins over a
// clear in the same cycle. Assumes fire_i is a single-cycle strobe.
module pmi_capture #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire_i,
    input  logic [W-1:0] word_i,
    input  logic         clr_i,
    output logic [W-1:0] capt_o,
    output logic         flag_o
);
    // Latch the input word on each interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)      capt_o <= '0;
        else if (fire_i) capt_o <= word_i;
    end

    // Sticky flag: set on fire, cleared by request.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (fire_i) flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/pattern_match_irq.sv
// Module: top of the masked pattern match interrupt. Holds the mode, mask
// and compare registers and wires synchronizer, detector and capture.
// Assumes IRQ_BIT < STAT_W and IRQ_BIT < W.
module pattern_match_irq
    import pmi_pkg::*;
#(
    parameter int unsigned W           = 32,
    parameter int unsigned STAT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      pin_in,
    input  logic [W-1:0]      wdata,
    input  logic              mode_we,
    input  logic              mask_we,
    input  logic              comp_we,
    input  logic              clr_we,
    output logic              irq_o,
    output logic [STAT_W-1:0] stat_o,
    output logic [W-1:0]      capt_o
);
    localparam int unsigned IRQ_BIT = PMI_IRQ_BIT;

    logic [1:0]   mode_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] comp_q;
    logic [W-1:0] sync_word;
    logic         fire;
    logic         clr_req;
    logic         flag;

    // Configuration registers written through their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PMI_OFF;
            mask_q <= '0;
            comp_q <= '0;
        end else begin
            if (mode_we) mode_q <= wdata[1:0];
            if (mask_we) mask_q <= wdata;
            if (comp_we) comp_q <= wdata;
        end
    end

    assign clr_req = clr_we & wdata[IRQ_BIT];

    pmi_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_in),
        .q_o   (sync_word)
    );

    pmi_detect #(.W(W)) i_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (sync_word),
        .mode_i (mode_q),
        .mask_i (mask_q),
        .comp_i (comp_q),
        .fire_o (fire)
    );

    pmi_capture #(.W(W)) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .word_i (sync_word),
        .clr_i  (clr_req),
        .capt_o (capt_o),
        .flag_o (flag)
    );

    assign irq_o = flag;

    generate
        for (genvar b = 0; b < STAT_W; b++) begin : g_stat
            if (b == IRQ_BIT) begin : g_flag
                assign stat_o[b] = flag;
            end else begin : g_zero
                assign stat_o[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pattern_match_irq_chk.sv
// Module: assertion checker bound to pattern_match_irq. Watches the
// detector strobe, the capture register and the sticky flag.
module pattern_match_irq_chk
    import pmi_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_q,
    input logic         fire,
    input logic [W-1:0] sync_word,
    input logic         clr_req,
    input logic         irq_o,
    input logic [W-1:0] capt_o
);
    // R2: a disabled block never raises a new request.
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != PMI_MATCH && mode_q != PMI_EVENT && !irq_o) |=> !irq_o);

    // R4: a match interrupt does not repeat on the next cycle.
    p_match_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == PMI_MATCH) |=> !(fire && mode_q == PMI_MATCH));

    // R6: capture takes the triggering word and the flag is set.
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (capt_o == $past(sync_word) && irq_o));

    // R6: capture holds without an interrupt.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(capt_o));

    // R7: the flag stays set until cleared.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_req) |=> irq_o);

    // R7: a clear without a coincident interrupt drops the flag.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !fire) |=> !irq_o);
endmodule

bind pattern_match_irq pattern_match_irq_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .fire      (fire),
    .sync_word (sync_word),
    .clr_req   (clr_req),
    .irq_o     (irq_o),
    .capt_o    (capt_o)
);

// File: tb/test_pattern_match_irq.sv
module test_pattern_match_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic [31:0] wdata = '0;
    logic        mode_we = 1'b0, mask_we = 1'b0, comp_we = 1'b0, clr_we = 1'b0;
    logic        irq_o;
    logic [7:0]  stat_o;
    logic [31:0] capt_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pattern_match_irq i_pattern_match_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wdata(wdata),
        .mode_we(mode_we), .mask_we(mask_we), .comp_we(comp_we), .clr_we(clr_we),
        .irq_o(irq_o), .stat_o(stat_o), .capt_o(capt_o)
    );

    // Behavioural reference model.
    logic [31:0] hist[$];
    logic [1:0]  m_mode;
    logic [31:0] m_mask, m_comp, m_capt;
    logic        m_irq, m_prev_match;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {32'h0, 32'h0, 32'h0};
            m_mode = 0; m_mask = 0; m_comp = 0; m_capt = 0;
            m_irq = 0; m_prev_match = 0;
        end else begin
            logic [31:0] cur, old;
            bit is_match, is_change, fires;
            cur = hist[1];
            old = hist[2];
            is_match  = ((cur ^ m_comp) & ~m_mask) == 32'h0;
            is_change = ((cur ^ old) & ~m_mask) != 32'h0;
            fires = (m_mode == 2'd1 && is_match && !m_prev_match) ||
                    (m_mode == 2'd2 && is_change);
            m_prev_match = is_match;
            if (fires) begin
                m_capt = cur;
                m_irq  = 1'b1;
            end else if (clr_we && wdata[1]) begin
                m_irq = 1'b0;
            end
            if (mode_we) m_mode = wdata[1:0];
            if (mask_we) m_mask = wdata;
            if (comp_we) m_comp = wdata;
            hist.push_front(pin_in);
            while (hist.size() > 3) void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_run++;
            if (irq_o !== m_irq || stat_o !== {6'b0, m_irq, 1'b0}) begin
                n_fail++;
                $display("FAIL R7 model irq/stat: got %b/%h exp %b/%h", irq_o, stat_o, m_irq, {6'b0, m_irq, 1'b0});
            end
            n_run++;
            if (capt_o !== m_capt) begin
                n_fail++;
                $display("FAIL R6 model capture: got %h exp %h", capt_o, m_capt);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 mode, 1 mask, 2 compare, 3 clear
    task automatic wr(input int kind, input logic [31:0] d);
        wdata = d;
        mode_we = (kind == 0); mask_we = (kind == 1);
        comp_we = (kind == 2); clr_we = (kind == 3);
        @(negedge clk);
        mode_we = 0; mask_we = 0; comp_we = 0; clr_we = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check(irq_o == 0, "R1 irq", irq_o, 0);
        check(stat_o == 0, "R1 stat", stat_o, 0);
        check(capt_o == 0, "R1 capture", capt_o, 0);

        // R2 disabled: input toggles raise nothing
        pin_in = 32'hFFFF_FFFF; cyc(4);
        pin_in = 32'h0; cyc(4);
        check(irq_o == 0, "R2 disabled", irq_o, 0);

        // R9/R3/R4 match mode, upper half ignored
        wr(1, 32'hFFFF_0000);
        wr(2, 32'h0000_1234);
        wr(0, 32'd1);
        cyc(3);
        check(irq_o == 0, "R4 no match", irq_o, 0);
        pin_in = 32'hABCD_1234; cyc(3);
        check(irq_o == 1, "R4 match fires", irq_o, 1);
        check(stat_o == 8'h02, "R7 status bit1", stat_o, 8'h02);
        check(capt_o == 32'hABCD_1234, "R6 capture", capt_o, 32'hABCD_1234);
        wr(3, 32'h2);
        check(irq_o == 0, "R7 clear", irq_o, 0);
        cyc(5);
        check(irq_o == 0, "R4 no refire while held", irq_o, 0);
        pin_in = 32'h5555_1234; cyc(4);
        check(irq_o == 0, "R3 masked bits ignored", irq_o, 0);
        check(capt_o == 32'hABCD_1234, "R6 capture held", capt_o, 32'hABCD_1234);
        pin_in = 32'h5555_1235; cyc(4);
        pin_in = 32'h5555_1234; cyc(3);
        check(irq_o == 1, "R4 refire after leaving", irq_o, 1);
        check(capt_o == 32'h5555_1234, "R6 new capture", capt_o, 32'h5555_1234);
        wr(3, 32'h1);
        check(irq_o == 1, "R7 clear bit1=0 no effect", irq_o, 1);
        wr(3, 32'h2);

        // R5/R8 event mode, only bits 15:8 watched
        wr(1, 32'hFFFF_00FF);
        wr(0, 32'd2);
        cyc(4);
        check(irq_o == 0, "R5 quiet", irq_o, 0);
        pin_in = 32'h5555_1235; cyc(4);
        check(irq_o == 0, "R3 masked change", irq_o, 0);
        pin_in = 32'h5555_1335; cyc(2);
        check(irq_o == 0, "R8 not yet", irq_o, 0);
        cyc(1);
        check(irq_o == 1, "R5 R8 event fires", irq_o, 1);
        check(capt_o == 32'h5555_1335, "R6 event capture", capt_o, 32'h5555_1335);
        wr(3, 32'h2);
        cyc(4);
        check(irq_o == 0, "R5 no change no fire", irq_o, 0);

        // R2 encoding 3 is disabled
        wr(0, 32'd3);
        pin_in = 32'h0000_0000; cyc(5);
        check(irq_o == 0, "R2 mode3 disabled", irq_o, 0);

        // Random run checked by the model (R4 R5 R7 set-wins)
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 19);
            pin_in = pin_in ^ (32'h1 << $urandom_range(0, 7));
            if (r == 0)      wr(0, 32'($urandom_range(0, 3)));
            else if (r == 1) wr(1, {$urandom, 8'h0} >> 8 | 32'hFFFF_FF00 & $urandom);
            else if (r == 2) wr(2, {24'h0, 8'($urandom)});
            else if (r < 6)  wr(3, 32'($urandom_range(0, 3)) << 0);
            else             cyc(1);
        end

        cyc(2);
        finish_run();
    end
endmodule